// File: doc/BRIEF.md
# Page-Table Accessed/Dirty Update Gate

This block sits inside a page-table walker, after a leaf entry has been fetched and its permissions checked. For each translation it decides one of two things. The block may set the Accessed and Dirty flags of the entry in hardware and write the changed entry back to memory. Otherwise it reports a page fault, so that software can set the flags itself.

The choice depends on two static strap inputs and two software enable bits. One strap says that the fault-on-missing-flag extension is present. The other says that the hardware-update extension is present. The two enable bits sit in a machine-level and a hypervisor-level environment configuration register, and this block holds both bits. A write-back goes out on a valid/ready memory write port. Success is reported only after that write has been accepted, and no new request is taken while it is pending.

Top module: `ad_update_gate`

## Requirements
- R1: After reset, `cfg_m_adue` is 1 only when `ext_hwupd` is 1 and `ext_fault` is 0. `cfg_h_adue` is 0 after reset in every strap combination.
- R2: A configuration write (`cfg_wr_en`=1, `cfg_wr_sel`=0 for machine, 1 for hypervisor) loads `cfg_wr_val` into the selected bit only when `ext_hwupd`=1. When `ext_hwupd`=0, both bits read 0 and writes leave them unchanged.
- R3: The base hardware-update enable is `cfg_m_adue` when `ext_hwupd`=1, and it is NOT `ext_fault` when `ext_hwupd`=0. Straps 0/0 therefore always update, and straps fault-only never update.
- R4: When a request has `req_first_stage`, `req_two_stage` and `req_virt` all set, the enable is additionally ANDed with `cfg_h_adue`.
- R5: When the enable is set, the response entry equals the fetched entry with bit 6 (Accessed) set, and also bit 7 (Dirty) set if `req_store`=1. No other bit changes.
- R6: When the enable is clear, a fault is reported if bit 6 is 0, or if `req_store`=1 and bit 7 is 0. Otherwise success is reported with the entry unchanged and no write-back.
- R7: A write-back is issued only when the updated entry differs from the fetched one and `req_debug`=0. A debug access returns the updated entry without writing it.
- R8: `wb_valid` rises one cycle after the request is accepted. It is held with a stable `wb_addr`/`wb_data` until `wb_ready`. `rsp_valid` (success) follows one cycle after the accepting edge, and `req_ready` is 0 throughout.
- R9: A request that needs no write-back yields a one-cycle `rsp_valid` pulse in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_fault | input | 1 | Strap: fault-on-missing-flag extension present |
| ext_hwupd | input | 1 | Strap: hardware-update extension present |
| cfg_wr_en | input | 1 | Software write strobe for an enable bit |
| cfg_wr_sel | input | 1 | 0 = machine bit, 1 = hypervisor bit |
| cfg_wr_val | input | 1 | Value to write |
| cfg_m_adue | output | 1 | Machine-level update enable bit |
| cfg_h_adue | output | 1 | Hypervisor-level update enable bit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_pte | input | PTE_W | Fetched leaf entry |
| req_pte_addr | input | ADDR_W | Physical address of the entry |
| req_store | input | 1 | Access is a data store |
| req_debug | input | 1 | Debug access, never written back |
| req_first_stage | input | 1 | Walk is the first translation stage |
| req_two_stage | input | 1 | Two-stage translation configured |
| req_virt | input | 1 | Virtualization active |
| wb_valid | output | 1 | Write-back request |
| wb_ready | input | 1 | Write-back accepted |
| wb_addr | output | ADDR_W | Write-back address |
| wb_data | output | PTE_W | Updated entry to write |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Page fault for a missing flag |
| rsp_pte | output | PTE_W | Entry to use for the translation |

## Verification
The assertions check on every cycle the write-back handshake: the data is held stable, no request is accepted while a write is pending, and success follows acceptance. They also check that every successful response carries Accessed, and Dirty for stores. They check that a written entry always differs from the fetched one, and that the enable bits stay zero without the hardware-update strap. Only the bench's scenarios can show the four strap combinations, the strap-dependent reset value, and the software switching between modes. The same holds for the hypervisor gating of virtualized first-stage walks and for the suppression of writes for debug accesses.

// File: rtl/ad_gate_pkg.sv
package ad_gate_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WB   = 1'b1
    } gate_state_e;

    typedef struct packed {
        logic m_adue;
        logic h_adue;
    } adue_cfg_t;

    localparam logic SEL_MACHINE = 1'b0;
    localparam logic SEL_HYPER   = 1'b1;

endpackage

// File: rtl/ad_cfg_regs.sv
module ad_cfg_regs
    import ad_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ext_fault,
    input  logic      ext_hwupd,
    input  logic      wr_en,
    input  logic      wr_sel,
    input  logic      wr_val,
    output adue_cfg_t cfg_q
);

    adue_cfg_t cfg_d;
    adue_cfg_t cfg_rst;

    always_comb begin
        cfg_rst        = '0;
        cfg_rst.m_adue = ext_hwupd & ~ext_fault;
    end

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && ext_hwupd) begin
            if (wr_sel == SEL_HYPER) cfg_d.h_adue = wr_val;
            else                     cfg_d.m_adue = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= cfg_rst;
        else        cfg_q <= cfg_d;
    end

    // R2: without the hardware-update strap the bits never leave zero
    a_r2_ro_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_hwupd |-> (cfg_q == '0));

endmodule

// File: rtl/ad_enable_resolve.sv
module ad_enable_resolve (
    input  logic ext_fault,
    input  logic ext_hwupd,
    input  logic m_adue,
    input  logic h_adue,
    input  logic first_stage,
    input  logic two_stage,
    input  logic virt,
    output logic enable
);

    logic base_en;
    logic guest_walk;

    always_comb begin
        base_en    = ext_hwupd ? m_adue : ~ext_fault;
        guest_walk = first_stage & two_stage & virt;
        enable     = guest_walk ? (base_en & h_adue) : base_en;
    end

endmodule

// File: rtl/ad_pte_update.sv
module ad_pte_update #(
    parameter int PTE_W = 64,
    parameter int A_BIT = 6,
    parameter int D_BIT = 7
) (
    input  logic [PTE_W-1:0] pte_in,
    input  logic             store,
    input  logic             debug,
    input  logic             enable,
    output logic [PTE_W-1:0] pte_out,
    output logic             fault,
    output logic             need_wb
);

    localparam logic [PTE_W-1:0] A_MASK = PTE_W'(1) << A_BIT;
    localparam logic [PTE_W-1:0] D_MASK = PTE_W'(1) << D_BIT;

    logic [PTE_W-1:0] set_mask;
    logic             flag_missing;

    always_comb begin
        set_mask     = A_MASK | (store ? D_MASK : '0);
        flag_missing = ~pte_in[A_BIT] | (store & ~pte_in[D_BIT]);
        if (enable) begin
            pte_out = pte_in | set_mask;
            fault   = 1'b0;
            need_wb = (pte_out != pte_in) & ~debug;
        end else begin
            pte_out = pte_in;
            fault   = flag_missing;
            need_wb = 1'b0;
        end
    end

endmodule

// File: rtl/ad_update_gate.sv
module ad_update_gate
    import ad_gate_pkg::*;
#(
    parameter int PTE_W  = 64,
    parameter int ADDR_W = 56,
    parameter int A_BIT  = 6,
    parameter int D_BIT  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_fault,
    input  logic              ext_hwupd,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_sel,
    input  logic              cfg_wr_val,
    output logic              cfg_m_adue,
    output logic              cfg_h_adue,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PTE_W-1:0]  req_pte,
    input  logic [ADDR_W-1:0] req_pte_addr,
    input  logic              req_store,
    input  logic              req_debug,
    input  logic              req_first_stage,
    input  logic              req_two_stage,
    input  logic              req_virt,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [PTE_W-1:0]  wb_data,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [PTE_W-1:0]  rsp_pte
);

    typedef struct packed {
        gate_state_e       state;
        logic [ADDR_W-1:0] wb_addr;
        logic [PTE_W-1:0]  wb_data;
        logic [PTE_W-1:0]  orig_pte;
        logic              rsp_valid;
        logic              rsp_fault;
        logic              rsp_store;
        logic [PTE_W-1:0]  rsp_pte;
    } gate_regs_t;

    adue_cfg_t        cfg_q;
    logic             eff_en;
    logic [PTE_W-1:0] upd_pte;
    logic             upd_fault;
    logic             upd_need_wb;
    gate_regs_t       r_d;
    gate_regs_t       r_q;

    ad_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_fault (ext_fault),
        .ext_hwupd (ext_hwupd),
        .wr_en     (cfg_wr_en),
        .wr_sel    (cfg_wr_sel),
        .wr_val    (cfg_wr_val),
        .cfg_q     (cfg_q)
    );

    ad_enable_resolve u_en (
        .ext_fault   (ext_fault),
        .ext_hwupd   (ext_hwupd),
        .m_adue      (cfg_q.m_adue),
        .h_adue      (cfg_q.h_adue),
        .first_stage (req_first_stage),
        .two_stage   (req_two_stage),
        .virt        (req_virt),
        .enable      (eff_en)
    );

    ad_pte_update #(
        .PTE_W (PTE_W),
        .A_BIT (A_BIT),
        .D_BIT (D_BIT)
    ) u_upd (
        .pte_in  (req_pte),
        .store   (req_store),
        .debug   (req_debug),
        .enable  (eff_en),
        .pte_out (upd_pte),
        .fault   (upd_fault),
        .need_wb (upd_need_wb)
    );

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.orig_pte  = req_pte;
                    r_d.rsp_store = req_store;
                    r_d.rsp_pte   = upd_pte;
                    if (upd_need_wb) begin
                        r_d.state   = ST_WB;
                        r_d.wb_addr = req_pte_addr;
                        r_d.wb_data = upd_pte;
                    end else begin
                        r_d.rsp_valid = 1'b1;
                        r_d.rsp_fault = upd_fault;
                    end
                end
            end
            ST_WB: begin
                if (wb_ready) begin
                    r_d.state     = ST_IDLE;
                    r_d.rsp_valid = 1'b1;
                    r_d.rsp_fault = 1'b0;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        cfg_m_adue = cfg_q.m_adue;
        cfg_h_adue = cfg_q.h_adue;
        req_ready  = (r_q.state == ST_IDLE);
        wb_valid   = (r_q.state == ST_WB);
        wb_addr    = r_q.wb_addr;
        wb_data    = r_q.wb_data;
        rsp_valid  = r_q.rsp_valid;
        rsp_fault  = r_q.rsp_fault;
        rsp_pte    = r_q.rsp_pte;
    end

    // R7: a written entry always differs from the fetched one
    a_r7_wb_changes_entry: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_data != r_q.orig_pte));

    // R8: write-back held stable until accepted
    a_r8_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_data) && $stable(wb_addr)));

    // R8: no request accepted while a write is pending
    a_r8_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !req_ready);

    // R8: success reported right after the write is accepted
    a_r8_rsp_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_ready) |=> (rsp_valid && !rsp_fault && !wb_valid));

    // R5: every success carries the Accessed flag
    a_r5_success_accessed: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> rsp_pte[A_BIT]);

    // R5: every successful store carries the Dirty flag
    a_r5_store_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && r_q.rsp_store) |-> rsp_pte[D_BIT]);

endmodule

// File: tb/sim_ad_update_gate.sv
`timescale 1ns/1ps
module sim_ad_update_gate;

    localparam int PW = 64;
    localparam int AW = 56;
    localparam logic [PW-1:0] AM = 64'h40;
    localparam logic [PW-1:0] DM = 64'h80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_fault = 1'b0, ext_hwupd = 1'b0;
    logic cfg_wr_en = 1'b0, cfg_wr_sel = 1'b0, cfg_wr_val = 1'b0;
    logic cfg_m_adue, cfg_h_adue;
    logic req_valid = 1'b0, req_ready;
    logic [PW-1:0] req_pte = '0;
    logic [AW-1:0] req_pte_addr = '0;
    logic req_store = 1'b0, req_debug = 1'b0;
    logic req_first_stage = 1'b0, req_two_stage = 1'b0, req_virt = 1'b0;
    logic wb_valid, wb_ready = 1'b0;
    logic [AW-1:0] wb_addr;
    logic [PW-1:0] wb_data;
    logic rsp_valid, rsp_fault;
    logic [PW-1:0] rsp_pte;

    int checks = 0, errors = 0, cycles = 0, wb_delay = 0, wcnt = 0;
    string cur_tag = "R1";
    bit done = 0;

    always #5 clk = ~clk;

    ad_update_gate u0 (.*);

    // reference model state
    bit m_pend, m_rv, m_rf, m_m, m_h;
    logic [PW-1:0] m_wd, m_rp;
    logic [AW-1:0] m_wa;

    always @(posedge clk) begin
        bit en;
        logic [PW-1:0] np;
        if (!rst_n) begin
            m_pend = 0; m_rv = 0; m_rf = 0;
            m_m = ext_hwupd && !ext_fault; m_h = 0;
        end else begin
            m_rv = 0;
            if (m_pend) begin
                if (wb_ready) begin m_pend = 0; m_rv = 1; m_rf = 0; end
            end else if (req_valid) begin
                en = ext_hwupd ? m_m : !ext_fault;
                if (req_first_stage && req_two_stage && req_virt) en = en && m_h;
                if (en) begin
                    np = req_pte | AM | (req_store ? DM : '0);
                    m_rp = np;
                    if (np != req_pte && !req_debug) begin
                        m_pend = 1; m_wd = np; m_wa = req_pte_addr;
                    end else begin m_rv = 1; m_rf = 0; end
                end else begin
                    m_rv = 1; m_rp = req_pte;
                    m_rf = !req_pte[6] || (req_store && !req_pte[7]);
                end
            end
            if (cfg_wr_en && ext_hwupd) begin
                if (cfg_wr_sel) m_h = cfg_wr_val; else m_m = cfg_wr_val;
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(req_ready == !m_pend, "R8 req_ready", 64'(req_ready), 64'(!m_pend));
            chk(wb_valid == m_pend, "R8 wb_valid", 64'(wb_valid), 64'(m_pend));
            if (m_pend) begin
                chk(wb_data == m_wd, "R7 wb_data", wb_data, m_wd);
                chk(wb_addr == m_wa, "R8 wb_addr", 64'(wb_addr), 64'(m_wa));
            end
            chk(rsp_valid == m_rv, "R9 rsp_valid", 64'(rsp_valid), 64'(m_rv));
            if (m_rv) begin
                chk(rsp_fault == m_rf, "R6 rsp_fault", 64'(rsp_fault), 64'(m_rf));
                chk(rsp_pte == m_rp, "R5 rsp_pte", rsp_pte, m_rp);
            end
            chk(cfg_m_adue == m_m, "R2 cfg_m_adue", 64'(cfg_m_adue), 64'(m_m));
            chk(cfg_h_adue == m_h, "R2 cfg_h_adue", 64'(cfg_h_adue), 64'(m_h));
        end
    end

    // write-back acceptor with programmable latency
    always @(posedge clk) begin
        #1;
        if (wb_valid) begin
            wb_ready = (wcnt >= wb_delay);
            wcnt++;
        end else begin
            wb_ready = 0; wcnt = 0;
        end
    end

    task automatic send(input logic [PW-1:0] pte, input bit st, input bit dbg,
                        input bit fs, input bit ts, input bit vt, input string tag);
        cur_tag = tag;
        while (!req_ready) begin @(posedge clk); #2; end
        req_valid = 1; req_pte = pte; req_store = st; req_debug = dbg;
        req_first_stage = fs; req_two_stage = ts; req_virt = vt;
        req_pte_addr = AW'(pte[PW-1:8]) ^ 56'h00AB_CD00;
        @(posedge clk); #2;
        req_valid = 0;
        while (!req_ready) begin @(posedge clk); #2; end
        @(posedge clk); #2;
    endtask

    task automatic cfg_write(input bit sel, input bit val);
        cur_tag = "R2";
        cfg_wr_en = 1; cfg_wr_sel = sel; cfg_wr_val = val;
        @(posedge clk); #2;
        cfg_wr_en = 0;
    endtask

    task automatic basic_set(input string tag);
        send(64'h0000_0012_3450_000F, 0, 0, 0, 0, 0, tag);
        send(64'h0000_0012_3451_004F, 0, 0, 0, 0, 0, tag);
        send(64'h0000_0012_3452_004F, 1, 0, 0, 0, 0, tag);
        send(64'h0000_0012_3453_00CF, 1, 0, 0, 0, 0, tag);
        send(64'h0000_0012_3454_000F, 1, 0, 0, 0, 0, tag);
        send(64'h0000_0012_3455_00CF, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        for (int combo = 0; combo < 4; combo++) begin
            rst_n = 0;
            ext_hwupd = combo[0]; ext_fault = combo[1];
            repeat (3) @(posedge clk);
            #2; rst_n = 1;
            #1;
            cur_tag = "R1";
            chk(cfg_m_adue == (ext_hwupd && !ext_fault), "R1 reset m_adue",
                64'(cfg_m_adue), 64'(ext_hwupd && !ext_fault));
            chk(cfg_h_adue == 1'b0, "R1 reset h_adue", 64'(cfg_h_adue), 64'h0);
            @(posedge clk); #2;
            wb_delay = 0;
            basic_set("R3");
            send(64'h0000_0000_0000_00CF, 0, 0, 0, 0, 0, "R9");
            // R7 debug access never written back
            send(64'h0000_0000_0777_000F, 1, 1, 0, 0, 0, "R7");
            // R2 software toggles the machine bit
            cfg_write(0, !cfg_m_adue);
            chk(cfg_m_adue == (ext_hwupd ? !(ext_hwupd && !ext_fault) : 1'b0),
                "R2 m_adue after write", 64'(cfg_m_adue), 64'(ext_hwupd && ext_fault));
            basic_set("R5");
            cfg_write(0, 1);
            // R4 virtualized first-stage walks gated by hypervisor bit
            send(64'h0000_0000_0888_000F, 1, 0, 1, 1, 1, "R4");
            cfg_write(1, 1);
            send(64'h0000_0000_0889_000F, 1, 0, 1, 1, 1, "R4");
            send(64'h0000_0000_088A_000F, 0, 0, 1, 0, 1, "R4");
            cfg_write(0, 0);
            send(64'h0000_0000_088B_000F, 0, 0, 1, 1, 1, "R6");
            send(64'h0000_0000_088C_004F, 1, 0, 0, 0, 0, "R6");
            cfg_write(0, 1);
            // R8 slow write-back acceptance
            wb_delay = 3;
            basic_set("R8");
            wb_delay = 1;
            send(64'h0000_0000_099D_000F, 1, 0, 0, 0, 0, "R8");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule